// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the device side of a double-data-rate SDRAM interface. On every rising clock edge it samples chip select, the three strobes (row, column, write enable), the clock enable, the bank address, address bit 8 and the data mask. It then classifies the pin state as exactly one command. The clock-enable level from the previous edge and the level at the current edge both take part in that classification. Address bit 8 has two uses: it selects auto-precharge on reads and writes, and it selects precharge of all banks on a precharge.

The block holds an idle/active flag for every bank, a small burst tracker of fixed length, and a device mode: normal, self refresh, power down or clock suspend. Every command is checked against that state. A command that is not allowed raises a one-cycle illegal flag and has no effect. All outputs are registered, so the result for the pins sampled at one edge appears right after that edge. A model of a memory device, or a protocol monitor, can use the block as its command front end.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Each edge produces exactly one bit of `cmd_o`, valid right after the edge that sampled the pins. Bit map: 0 deselect, 1 no-op, 2 activate, 3 precharge one bank, 4 precharge all, 5 write, 6 read, 7 base mode-register load, 8 extended mode-register load, 9 auto refresh, 10 self-refresh entry, 11 power-down entry, 12 low-power exit, 13 burst stop. `bank_o` carries the bank address for activate, precharge-one, read, write and both mode loads, and is 0 otherwise.
- R2: With chip select high the command is deselect, whatever the other pins are. With chip select low and all three strobes high it is no-op. Strobe patterns are written {ras_n,cas_n,we_n}.
- R3: Activate (011) is legal only on an idle bank, and it makes that bank active.
- R4: Precharge (010) with A8 low idles only the addressed bank. With A8 high it idles every bank, and the bank bits are ignored. Precharge is legal in any bank state.
- R5: Write (100) and read (101) are legal only on an active bank. `auto_pre_o` reports A8. A legal read or write raises `in_burst_o` for BURST_LEN edges of normal mode. With auto-precharge set, the bank goes idle at the edge where the burst ends.
- R6: Mode load (000) is legal only when all banks are idle. Bank address 0 selects the base register and 1 selects the extended register. Bank addresses 2 and 3 are illegal.
- R7: Pattern 001 with clock enable high at both edges is auto refresh. With clock enable falling it is self-refresh entry, and `mode_o` becomes 1. Both need every bank idle.
- R8: Deselect or no-op with clock enable falling enters power down (`mode_o` 2). If a burst is in progress the device enters clock suspend instead (`mode_o` 3), and the burst count is frozen while in suspend.
- R9: Deselect or no-op with clock enable rising is the exit command, and it returns `mode_o` to normal (0).
- R10: Burst stop (110) is legal only while a read burst runs. It ends the burst at once and idles the bank if that burst had auto-precharge.
- R11: `data_en_o` is high after an edge where the data mask was low, the device was in normal mode and at least one bank was active. Otherwise it is low.
- R12: An illegal command raises `illegal_o` for that one cycle and leaves bank and mode state unchanged. Only a running burst's own auto-precharge may still close its bank on that edge. Any command other than deselect or no-op is illegal when the device is outside normal mode, when clock enable was low at the previous edge, or when clock enable is low at the current edge. A read or write during a burst with auto-precharge is also illegal.
- R13: Reset, active low and asynchronous, clears all banks to idle, sets the mode to normal, clears the burst, drives `cmd_o` to deselect, and clears `illegal_o` and `data_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, commands sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 2 | Bank address |
| a8_i | input | 1 | Address bit 8 (auto-precharge / all-bank select) |
| dm_i | input | 1 | Data mask |
| cmd_o | output | 14 | One-hot decoded command |
| bank_o | output | 2 | Target bank of the command |
| auto_pre_o | output | 1 | Read or write with auto-precharge |
| illegal_o | output | 1 | Command not allowed in current state |
| bank_active_o | output | 4 | Per-bank active flag |
| mode_o | output | 2 | Device mode: 0 normal, 1 self refresh, 2 power down, 3 clock suspend |
| in_burst_o | output | 1 | Read or write burst in progress |
| data_en_o | output | 1 | Data write or output enabled |

## Verification
Every strobe pattern is driven with clock enable held high, falling, rising and held low, so that each code and each legality rule is tried. Activate, read, write and mode loads are each sent once against idle banks and once against active banks, which separates the state checks from the raw decode. Power-down requests are made both with no burst running and with a burst running, which shows whether clock suspend is chosen and whether the burst count freezes. Burst stop and auto-precharge are exercised at both ends of a burst. Each edge is compared against a behavioural model on all outputs.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int unsigned CMD_DESEL = 0;
  localparam int unsigned CMD_NOP   = 1;
  localparam int unsigned CMD_ACT   = 2;
  localparam int unsigned CMD_PRE   = 3;
  localparam int unsigned CMD_PREA  = 4;
  localparam int unsigned CMD_WR    = 5;
  localparam int unsigned CMD_RD    = 6;
  localparam int unsigned CMD_MRS   = 7;
  localparam int unsigned CMD_EMRS  = 8;
  localparam int unsigned CMD_AREF  = 9;
  localparam int unsigned CMD_SREF  = 10;
  localparam int unsigned CMD_PDE   = 11;
  localparam int unsigned CMD_EXIT  = 12;
  localparam int unsigned CMD_BST   = 13;
  localparam int unsigned CMD_N     = 14;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SELF    = 2'd1,
    MODE_PDOWN   = 2'd2,
    MODE_SUSPEND = 2'd3
  } dev_mode_e;
endpackage

// File: rtl/sdram_cmd_class.sv
module sdram_cmd_class
  import sdram_dec_pkg::*;
#(
  parameter int unsigned BA_W = 2
) (
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic            cke_prev_i,
  input  logic            cke_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a8_i,
  output logic [CMD_N-1:0] cmd_oh_o
);
  logic idle_cmd;

  always_comb begin
    cmd_oh_o = '0;
    idle_cmd = 1'b0;
    if (cs_ni) begin
      cmd_oh_o[CMD_DESEL] = 1'b1;
      idle_cmd = 1'b1;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111: begin cmd_oh_o[CMD_NOP] = 1'b1; idle_cmd = 1'b1; end
        3'b011: cmd_oh_o[CMD_ACT] = 1'b1;
        3'b010: if (a8_i) cmd_oh_o[CMD_PREA] = 1'b1; else cmd_oh_o[CMD_PRE] = 1'b1;
        3'b100: cmd_oh_o[CMD_WR] = 1'b1;
        3'b101: cmd_oh_o[CMD_RD] = 1'b1;
        3'b000: if (ba_i == BA_W'(1)) cmd_oh_o[CMD_EMRS] = 1'b1; else cmd_oh_o[CMD_MRS] = 1'b1;
        3'b001: if (cke_prev_i && !cke_i) cmd_oh_o[CMD_SREF] = 1'b1; else cmd_oh_o[CMD_AREF] = 1'b1;
        default: cmd_oh_o[CMD_BST] = 1'b1;
      endcase
    end
    // clock-enable edges turn idle cycles into low-power entry/exit
    if (idle_cmd && (cke_prev_i != cke_i)) begin
      cmd_oh_o = '0;
      if (cke_i) cmd_oh_o[CMD_EXIT] = 1'b1;
      else       cmd_oh_o[CMD_PDE]  = 1'b1;
    end
  end
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 pre_i,
  input  logic                 pre_all_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 close_i,
  input  logic [BA_W-1:0]      close_bank_i,
  output logic [NUM_BANKS-1:0] active_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, close_hit;
    assign hit       = (bank_i == BA_W'(b));
    assign close_hit = close_i && (close_bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     active_o[b] <= 1'b0;
      else if (act_i && hit)                           active_o[b] <= 1'b1;
      else if (pre_all_i || (pre_i && hit) || close_hit) active_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned BA_W      = 2,
  localparam int unsigned CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_read_i,
  input  logic            ap_i,
  input  logic [BA_W-1:0] bank_i,
  input  logic            stop_i,
  input  logic            run_i,
  output logic            busy_o,
  output logic            rd_o,
  output logic            ap_o,
  output logic            close_o,
  output logic [BA_W-1:0] bank_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_o   <= 1'b0;
      ap_o   <= 1'b0;
      bank_o <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(BURST_LEN);
      rd_o   <= is_read_i;
      ap_o   <= ap_i;
      bank_o <= bank_i;
    end else if (stop_i) begin
      cnt_q <= '0;
    end else if (run_i && busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign close_o = ap_o && busy_o &&
                   (stop_i || (run_i && !start_i && cnt_q == CNT_W'(1)));
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 cke_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a8_i,
  input  logic                 dm_i,
  output logic [CMD_N-1:0]     cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic                 auto_pre_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic [1:0]           mode_o,
  output logic                 in_burst_o,
  output logic                 data_en_o
);
  logic            cke_q;
  logic [CMD_N-1:0] c;
  dev_mode_e       mode_q, mode_d;
  logic            legal, normal, bank_act, all_idle;
  logic            busy, b_rd, b_ap, b_close;
  logic [BA_W-1:0] b_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  sdram_cmd_class #(.BA_W(BA_W)) u_class (
    .cs_ni, .ras_ni, .cas_ni, .we_ni,
    .cke_prev_i(cke_q), .cke_i, .ba_i, .a8_i,
    .cmd_oh_o(c)
  );

  assign normal   = (mode_q == MODE_NORMAL);
  assign bank_act = bank_active_o[ba_i];
  assign all_idle = ~|bank_active_o;

  always_comb begin
    legal = 1'b0;
    if (c[CMD_DESEL] || c[CMD_NOP] || c[CMD_EXIT]) begin
      legal = 1'b1;
    end else if (normal && cke_q) begin
      legal = c[CMD_PDE] || (c[CMD_SREF] && all_idle) ||
              (cke_i && ((c[CMD_ACT] && !bank_act) ||
                         c[CMD_PRE] || c[CMD_PREA] ||
                         ((c[CMD_WR] || c[CMD_RD]) && bank_act && !(busy && b_ap)) ||
                         ((c[CMD_MRS] || c[CMD_EMRS]) && all_idle && (ba_i <= BA_W'(1))) ||
                         (c[CMD_AREF] && all_idle) ||
                         (c[CMD_BST] && busy && b_rd)));
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (legal) begin
      if (c[CMD_SREF])      mode_d = MODE_SELF;
      else if (c[CMD_PDE])  mode_d = busy ? MODE_SUSPEND : MODE_PDOWN;
      else if (c[CMD_EXIT]) mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else         mode_q <= mode_d;
  end
  assign mode_o = mode_q;

  sdram_burst_track #(.BURST_LEN(BURST_LEN), .BA_W(BA_W)) u_burst (
    .clk_i, .rst_ni,
    .start_i  (legal && (c[CMD_WR] || c[CMD_RD])),
    .is_read_i(c[CMD_RD]),
    .ap_i     (a8_i),
    .bank_i   (ba_i),
    .stop_i   (legal && c[CMD_BST]),
    .run_i    (normal),
    .busy_o   (busy),
    .rd_o     (b_rd),
    .ap_o     (b_ap),
    .close_o  (b_close),
    .bank_o   (b_bank)
  );
  assign in_burst_o = busy;

  sdram_bank_state #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk_i, .rst_ni,
    .act_i       (legal && c[CMD_ACT]),
    .pre_i       (legal && c[CMD_PRE]),
    .pre_all_i   (legal && c[CMD_PREA]),
    .bank_i      (ba_i),
    .close_i     (b_close),
    .close_bank_i(b_bank),
    .active_o    (bank_active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= CMD_N'(1) << CMD_DESEL;
      bank_o     <= '0;
      auto_pre_o <= 1'b0;
      illegal_o  <= 1'b0;
      data_en_o  <= 1'b0;
    end else begin
      cmd_o      <= c;
      bank_o     <= (c[CMD_ACT] || c[CMD_PRE] || c[CMD_WR] || c[CMD_RD] ||
                     c[CMD_MRS] || c[CMD_EMRS]) ? ba_i : '0;
      auto_pre_o <= (c[CMD_WR] || c[CMD_RD]) && a8_i;
      illegal_o  <= !legal;
      data_en_o  <= !dm_i && normal && !all_idle;
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk
  import sdram_dec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CMD_N-1:0]     cmd_o,
  input logic [BA_W-1:0]      bank_o,
  input logic                 illegal_o,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic [1:0]           mode_o,
  input logic                 in_burst_o,
  input logic                 data_en_o
);
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) == 1);

  a_r3_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_ACT] && !illegal_o |-> bank_active_o[bank_o]);

  a_r12_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> mode_o == $past(mode_o));

  a_r12_banks_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o && !$past(in_burst_o) |-> bank_active_o == $past(bank_active_o));

  a_r7_sref_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd1 && $past(mode_o) == 2'd0 |-> cmd_o[CMD_SREF]);

  a_r9_exit_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_EXIT] |-> mode_o == 2'd0);

  a_r11_data_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> $past(mode_o) == 2'd0 && $past(bank_active_o) != '0);
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_o        (cmd_o),
  .bank_o       (bank_o),
  .illegal_o    (illegal_o),
  .bank_active_o(bank_active_o),
  .mode_o       (mode_o),
  .in_burst_o   (in_burst_o),
  .data_en_o    (data_en_o)
);

// File: tb/sdram_cmd_decoder_bench.sv
`timescale 1ns/1ps
module sdram_cmd_decoder_bench;
  localparam int BL = 4;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
    P_PRE = 4'b0010, P_WR = 4'b0100, P_RD = 4'b0101, P_MRS = 4'b0000,
    P_REF = 4'b0001, P_BST = 4'b0110;
  localparam int K_DES = 0, K_NOP = 1, K_ACT = 2, K_PRE = 3, K_PREA = 4, K_WR = 5,
    K_RD = 6, K_MRS = 7, K_EMRS = 8, K_AREF = 9, K_SREF = 10, K_PDE = 11,
    K_EXIT = 12, K_BST = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, ras_n, cas_n, we_n, cke, a8, dm;
  logic [1:0] ba;
  logic [13:0] cmd;
  logic [1:0] bank, mode;
  logic [3:0] bact;
  logic ap_o, ill, burst, den;

  sdram_cmd_decoder u_sdram_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .a8_i(a8), .dm_i(dm),
    .cmd_o(cmd), .bank_o(bank), .auto_pre_o(ap_o), .illegal_o(ill),
    .bank_active_o(bact), .mode_o(mode), .in_burst_o(burst), .data_en_o(den)
  );

  int n_chk = 0, n_fail = 0;
  // reference state
  int m_mode, m_act, m_cnt, m_bank;
  bit m_rd, m_ap, m_ckep;
  int e_code, e_bank;
  bit e_ap, e_ill, e_den;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "cmd", int'(cmd), 1 << e_code);
    chk(tag, "bank", int'(bank), e_bank);
    chk(tag, "auto_pre", int'(ap_o), int'(e_ap));
    chk(tag, "illegal", int'(ill), int'(e_ill));
    chk(tag, "banks", int'(bact), m_act);
    chk(tag, "mode", int'(mode), m_mode);
    chk(tag, "in_burst", int'(burst), int'(m_cnt > 0));
    chk(tag, "data_en", int'(den), int'(e_den));
  endtask

  task automatic model_reset();
    m_mode = 0; m_act = 0; m_cnt = 0; m_bank = 0; m_rd = 0; m_ap = 0; m_ckep = 1;
    e_code = K_DES; e_bank = 0; e_ap = 0; e_ill = 0; e_den = 0;
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = P_DES; cke = 1; ba = 0; a8 = 0; dm = 1;
    model_reset();
    @(negedge clk); @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
  endtask

  task automatic step(logic [3:0] p, logic ck, int b, logic a, logic d, string tag);
    bit legal, bank_on, busy, idle_all;
    int old_mode;
    {cs_n, ras_n, cas_n, we_n} = p; cke = ck; ba = 2'(b); a8 = a; dm = d;
    if (p[3]) e_code = K_DES;
    else case (p[2:0])
      3'b111: e_code = K_NOP;
      3'b011: e_code = K_ACT;
      3'b010: e_code = a ? K_PREA : K_PRE;
      3'b100: e_code = K_WR;
      3'b101: e_code = K_RD;
      3'b000: e_code = (b == 1) ? K_EMRS : K_MRS;
      3'b001: e_code = (m_ckep && !ck) ? K_SREF : K_AREF;
      default: e_code = K_BST;
    endcase
    if ((e_code == K_DES || e_code == K_NOP) && m_ckep != ck) e_code = ck ? K_EXIT : K_PDE;
    bank_on = m_act[b]; busy = m_cnt > 0; idle_all = (m_act == 0);
    legal = 0;
    if (e_code == K_DES || e_code == K_NOP || e_code == K_EXIT) legal = 1;
    else if (m_mode == 0 && m_ckep) begin
      if (e_code == K_PDE) legal = 1;
      else if (e_code == K_SREF) legal = idle_all;
      else if (ck) case (e_code)
        K_ACT: legal = !bank_on;
        K_PRE, K_PREA: legal = 1;
        K_WR, K_RD: legal = bank_on && !(busy && m_ap);
        K_MRS, K_EMRS: legal = idle_all && b < 2;
        K_AREF: legal = idle_all;
        K_BST: legal = busy && m_rd;
        default: legal = 0;
      endcase
    end
    e_bank = (e_code inside {K_ACT, K_PRE, K_WR, K_RD, K_MRS, K_EMRS}) ? b : 0;
    e_ap = (e_code == K_WR || e_code == K_RD) && a;
    e_ill = !legal;
    e_den = !d && !idle_all && m_mode == 0;
    old_mode = m_mode;
    if (legal) case (e_code)
      K_ACT: m_act |= (1 << b);
      K_PRE: m_act &= ~(1 << b);
      K_PREA: m_act = 0;
      K_SREF: m_mode = 1;
      K_PDE: m_mode = busy ? 3 : 2;
      K_EXIT: m_mode = 0;
      default: ;
    endcase
    if (legal && (e_code == K_WR || e_code == K_RD)) begin
      m_cnt = BL; m_rd = (e_code == K_RD); m_ap = a; m_bank = b;
    end else if (legal && e_code == K_BST) begin
      m_cnt = 0;
      if (m_ap) m_act &= ~(1 << m_bank);
    end else if (old_mode == 0 && m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0 && m_ap) m_act &= ~(1 << m_bank);
    end
    m_ckep = ck;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(logic ck, string tag);
    step(P_NOP, ck, 0, 0, 1, tag);
  endtask

  bit done = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R13");
    nop(1, "R2");
    step(4'b1000, 1, 3, 1, 1, "R2");          // cs high overrides low strobes
    step(P_RD, 1, 0, 0, 1, "R12");            // read on idle bank
    step(P_WR, 1, 1, 1, 1, "R12");
    step(P_MRS, 1, 0, 0, 1, "R6");
    step(P_MRS, 1, 1, 0, 1, "R6");
    step(P_MRS, 1, 2, 0, 1, "R6");            // reserved select
    step(P_REF, 1, 0, 0, 1, "R7");
    step(P_ACT, 1, 0, 0, 1, "R3");
    step(P_ACT, 1, 0, 0, 1, "R3");            // already active
    step(P_ACT, 1, 2, 0, 1, "R3");
    step(P_MRS, 1, 0, 0, 1, "R6");            // banks not idle
    step(P_REF, 1, 0, 0, 1, "R7");
    step(P_NOP, 1, 0, 0, 1, "R11");
    step(P_NOP, 1, 0, 0, 0, "R11");
    step(P_RD, 1, 0, 0, 0, "R5");
    nop(1, "R5");
    step(P_BST, 1, 0, 0, 1, "R10");
    step(P_BST, 1, 0, 0, 1, "R10");           // nothing to stop
    step(P_WR, 1, 2, 1, 0, "R5");
    step(P_WR, 1, 0, 0, 0, "R12");            // during auto-precharge burst
    step(P_BST, 1, 0, 0, 1, "R10");           // write burst cannot be stopped
    for (int i = 0; i < 3; i++) nop(1, "R5");
    step(P_PRE, 1, 0, 0, 1, "R4");
    step(P_ACT, 1, 1, 0, 1, "R3");
    step(P_ACT, 1, 3, 0, 1, "R3");
    step(P_PRE, 1, 1, 1, 1, "R4");            // all banks, bank bits ignored
    step(P_ACT, 1, 2, 0, 1, "R3");
    nop(0, "R8");
    step(P_ACT, 0, 1, 0, 1, "R12");           // in power down
    nop(0, "R8");
    nop(1, "R9");
    step(P_RD, 1, 2, 1, 1, "R5");
    nop(1, "R5");
    nop(0, "R8");                             // burst running: clock suspend
    nop(0, "R8");
    nop(0, "R8");
    nop(1, "R9");
    nop(1, "R8");
    step(P_BST, 1, 0, 0, 1, "R10");           // stop with auto-precharge closes bank
    step(P_REF, 0, 0, 0, 1, "R7");
    nop(0, "R7");
    step(P_REF, 0, 0, 0, 1, "R12");
    step(P_DES, 1, 0, 0, 1, "R9");
    step(P_ACT, 1, 1, 0, 1, "R3");
    step(P_REF, 0, 0, 0, 1, "R7");            // bank active: refused
    step(P_ACT, 1, 2, 0, 1, "R12");           // clock enable was low
    nop(1, "R9");
    step(P_ACT, 0, 2, 0, 1, "R12");           // falling with non-idle command
    nop(1, "R9");
    step(P_RD, 1, 1, 1, 0, "R5");
    nop(1, "R5");
    do_reset("R13");
    nop(1, "R13");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule